// File: doc/BRIEF.md
# Message-Based Configuration Register Slave

This block is a 16-bit register-file slave on a 16-bit-address, 16-bit-data bus. It answers in a 64-byte window of the short I/O space. The window holds an identity word, a device-type word, a control/status word and a set of message registers. The message registers appear twice: once for the bus master and once, with read and write roles swapped, for the local processor. Two groups of scratch RAM words let software test the slave at power-up. The window also holds a module-ID output register, an external address/data port and a location-monitor register.

The location monitor watches eight kinds of bus-side access to the message registers. When one happens and its enable bit is set, a sticky flag is set and an interrupt request is raised. In the interrupt-acknowledge cycle the slave returns its stored 8-bit vector. Every access is completed by a single-cycle acknowledge, one clock after the rising edge of the data strobe is seen.

Top module: `cfgslv_top`

## Requirements
- R1: The slave answers only addresses from BASE to BASE+3Fh, where BASE = LOG_ADDR*40h + C000h (C000h by default). Any other address gets no acknowledge. Address bit 0 is ignored.
- R2: `bus_ack` rises on the first clock edge at which `bus_ds` is sampled high after being low. It stays high for exactly one cycle, even if the strobe is held high. Read data is valid on `bus_rdata` from that edge on.
- R3: Offset 0 reads ID_WORD (default 3A7Ch) and offset 2 reads DEV_TYPE (default 5E10h). Writes to either offset leave them unchanged.
- R4: Offsets 10h–1Eh (eight words) and 28h–2Eh (four words) are independent read/write storage words.
- R5: A bus write at 08h is read by the processor at 38h, and a processor write at 38h is read by the bus at 08h. A bus write at 0Ah is read at 3Ah, and a processor write at 3Ah is read at 0Ah.
- R6: Data-high is one word reachable at both 0Ch and 3Ch, and data-low is one word reachable at both 0Eh and 3Eh.
- R7: For offset 20h, written bits 12–0 drive `modid_lines` and bit 13 drives `modid_oe`. The register reads back bits 13–0, and bits 15–14 read 0.
- R8: Offset 04h is a read/write control word, and its bits 7–0 enable monitors 0–7. The monitors fire on these bus-side accesses: 0 write 0Ch, 1 write 0Eh, 2 read 0Ch, 3 read 0Eh, 4 write 08h, 5 write 0Ah, 6 read 0Ah, 7 read 08h. An enabled event sets flag bit 8+i of offset 22h and raises `irq_req` with the acknowledge. Disabled events and processor-side accesses (38h–3Eh) set nothing.
- R9: A write to 22h loads the vector from bits 7–0 and clears every flag whose bit in 15–8 is 1. `irq_req` drops with that acknowledge once no enabled flag remains.
- R10: A strobe with `bus_iack` high is acknowledged whatever the address, and returns {8'h00, vector}.
- R11: Offsets 06h, 24h (on read) and 30h–36h read 0, and writes to 06h and 30h–36h change nothing.
- R12: A write at 24h sets `ext_addr`. A write at 26h sets `ext_wdata` and pulses `ext_wr_stb` in the acknowledge cycle. A read at 26h returns `ext_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ds | input | 1 | Data strobe; the rising edge starts an access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_iack | input | 1 | Interrupt-acknowledge cycle |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, held until the next read |
| bus_ack | output | 1 | One-cycle acknowledge |
| irq_req | output | 1 | Interrupt request |
| modid_lines | output | 13 | Module-ID lines |
| modid_oe | output | 1 | Module-ID output enable |
| ext_addr | output | 16 | External port address |
| ext_wdata | output | 16 | External port write data |
| ext_wr_stb | output | 1 | External write pulse |
| ext_rdata | input | 16 | External port read data |

## Verification
Every result is registered on the same edge as the acknowledge: read data, register updates, monitor flags, `irq_req`, `ext_wr_stb` and the module-ID outputs. All of them are therefore due one clock after the strobe is driven. The bench drives the strobe at a falling edge and samples every port at the next falling edge, then drops the strobe. One extra cycle is spent confirming that the acknowledge has fallen. The timing scenario also checks that the acknowledge is absent before that edge and absent a cycle later while the strobe is still high.

// File: rtl/cfgslv_pkg.sv
`timescale 1ns/1ps
package cfgslv_pkg;
  localparam int DW      = 16;
  localparam int AW      = 16;
  localparam int WIX     = 5;
  localparam int MON_N   = 8;
  localparam int VEC_W   = 8;
  localparam int RAM_N   = 12;
  localparam int RIX     = $clog2(RAM_N);
  localparam int MODID_W = 13;
  localparam logic [AW-1:0] SHORT_IO_BASE = 16'hC000;

  typedef enum logic [WIX-1:0] {
    W_ID = 5'd0, W_DEV = 5'd1, W_CSR = 5'd2, W_OFS = 5'd3,
    W_SIGPRO = 5'd4, W_RSPEXT = 5'd5, W_DHI = 5'd6, W_DLO = 5'd7,
    W_MODID = 5'd16, W_LMON = 5'd17, W_XADR = 5'd18, W_XDAT = 5'd19,
    W_PSIG = 5'd28, W_PRSP = 5'd29, W_PDHI = 5'd30, W_PDLO = 5'd31
  } word_e;

  // monitor event numbering
  localparam int EV_WR_DHI = 0;
  localparam int EV_WR_DLO = 1;
  localparam int EV_RD_DHI = 2;
  localparam int EV_RD_DLO = 3;
  localparam int EV_WR_SIG = 4;
  localparam int EV_WR_XD  = 5;
  localparam int EV_RD_RSP = 6;
  localparam int EV_RD_PRO = 7;

  function automatic logic [AW-1:0] blk_base(input logic [7:0] la);
    return SHORT_IO_BASE + {2'b00, la, 6'b000000};
  endfunction

  function automatic logic is_ram(input logic [WIX-1:0] w);
    return (w[4:3] == 2'b01) || (w[4:2] == 3'b101);
  endfunction

  function automatic logic [RIX-1:0] ram_idx(input logic [WIX-1:0] w);
    return w[4] ? {2'b10, w[1:0]} : {1'b0, w[2:0]};
  endfunction
endpackage

// File: rtl/cfgslv_decode.sv
`timescale 1ns/1ps
module cfgslv_decode
  import cfgslv_pkg::*;
#(
  parameter logic [7:0] LOG_ADDR = 8'd0
) (
  input  logic [AW-1:1]  addr_w,
  output logic           hit,
  output logic [WIX-1:0] word
);
  localparam logic [AW-1:0] BASE = blk_base(LOG_ADDR);

  always_comb begin
    hit  = (addr_w[AW-1:WIX+1] == BASE[AW-1:WIX+1]);
    word = addr_w[WIX:1];
  end
endmodule

// File: rtl/cfgslv_locmon.sv
`timescale 1ns/1ps
module cfgslv_locmon
  import cfgslv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MON_N-1:0] evt,
  input  logic [MON_N-1:0] en,
  input  logic             lm_wr,
  input  logic [DW-1:0]    lm_wdata,
  output logic [MON_N-1:0] flags,
  output logic [VEC_W-1:0] vector,
  output logic             irq
);
  logic [MON_N-1:0] flags_q;
  logic [VEC_W-1:0] vec_q;
  logic [MON_N-1:0] clr_mask;
  logic [MON_N-1:0] arm;

  assign clr_mask = lm_wr ? lm_wdata[VEC_W +: MON_N] : '0;
  assign arm      = evt & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      vec_q   <= '0;
    end else begin
      for (int i = 0; i < MON_N; i++) begin
        if (arm[i])          flags_q[i] <= 1'b1;
        else if (clr_mask[i]) flags_q[i] <= 1'b0;
      end
      if (lm_wr) vec_q <= lm_wdata[VEC_W-1:0];
    end
  end

  assign flags  = flags_q;
  assign vector = vec_q;
  assign irq    = |(flags_q & en);

  AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_q & ~$past(flags_q))) |-> $past(|arm)) else $error("flag set without event"); // R8
  AST_CLEAR_ALL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (lm_wr && (&lm_wdata[VEC_W +: MON_N]) && !(|arm)) |=> !irq) else $error("irq kept"); // R9
  AST_VECTOR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lm_wr |=> (vector == $past(lm_wdata[VEC_W-1:0]))) else $error("vector not loaded"); // R9
endmodule

// File: rtl/cfgslv_top.sv
`timescale 1ns/1ps
module cfgslv_top
  import cfgslv_pkg::*;
#(
  parameter logic [7:0]    LOG_ADDR = 8'd0,
  parameter logic [DW-1:0] ID_WORD  = 16'h3A7C,
  parameter logic [DW-1:0] DEV_TYPE = 16'h5E10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_ds,
  input  logic               bus_wr,
  input  logic               bus_iack,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_ack,
  output logic               irq_req,
  output logic [MODID_W-1:0] modid_lines,
  output logic               modid_oe,
  output logic [AW-1:0]      ext_addr,
  output logic [DW-1:0]      ext_wdata,
  output logic               ext_wr_stb,
  input  logic [DW-1:0]      ext_rdata
);
  localparam logic [AW-1:0] BASE     = blk_base(LOG_ADDR);
  localparam logic [AW-1:0] BLK_LAST = BASE + 16'd63;

  // access events
  logic           ds_q;
  logic           ds_seen;
  logic           hit;
  logic [WIX-1:0] word;
  logic           acc_go, iack_go, wr_go, rd_go;

  always_ff @(posedge clk) begin
    if (!rst_n) ds_q <= 1'b0;
    else        ds_q <= bus_ds;
  end

  assign ds_seen = bus_ds & ~ds_q;
  assign acc_go  = ds_seen & hit & ~bus_iack;
  assign iack_go = ds_seen & bus_iack;
  assign wr_go   = acc_go & bus_wr;
  assign rd_go   = acc_go & ~bus_wr;

  cfgslv_decode #(.LOG_ADDR(LOG_ADDR)) u_dec (
    .addr_w (bus_addr[AW-1:1]),
    .hit    (hit),
    .word   (word)
  );

  // register storage
  logic [DW-1:0]      ctrl_q, sig_q, pro_q, rsp_q, msg_xd_q, dhi_q, dlo_q;
  logic [MODID_W:0]   modid_q;
  logic [AW-1:0]      xadr_q;
  logic [DW-1:0]      xwd_q;
  logic [DW-1:0]      ram_q [RAM_N];
  logic               xstb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; sig_q <= '0; pro_q <= '0; rsp_q <= '0; msg_xd_q <= '0;
      dhi_q <= '0; dlo_q <= '0; modid_q <= '0; xadr_q <= '0; xwd_q <= '0;
      xstb_q <= 1'b0;
      for (int i = 0; i < RAM_N; i++) ram_q[i] <= '0;
    end else begin
      xstb_q <= wr_go && (word == W_XDAT);
      if (wr_go) begin
        case (word)
          W_CSR:           ctrl_q   <= bus_wdata;
          W_SIGPRO:        sig_q    <= bus_wdata;
          W_RSPEXT:        msg_xd_q <= bus_wdata;
          W_DHI, W_PDHI:   dhi_q    <= bus_wdata;
          W_DLO, W_PDLO:   dlo_q    <= bus_wdata;
          W_MODID:         modid_q  <= bus_wdata[MODID_W:0];
          W_XADR:          xadr_q   <= bus_wdata;
          W_XDAT:          xwd_q    <= bus_wdata;
          W_PSIG:          pro_q    <= bus_wdata;
          W_PRSP:          rsp_q    <= bus_wdata;
          default: if (is_ram(word)) ram_q[ram_idx(word)] <= bus_wdata;
        endcase
      end
    end
  end

  // location monitor
  logic [MON_N-1:0] mon_evt;
  logic [MON_N-1:0] mon_flags;
  logic [VEC_W-1:0] mon_vec;

  always_comb begin
    mon_evt            = '0;
    mon_evt[EV_WR_DHI] = wr_go && (word == W_DHI);
    mon_evt[EV_WR_DLO] = wr_go && (word == W_DLO);
    mon_evt[EV_RD_DHI] = rd_go && (word == W_DHI);
    mon_evt[EV_RD_DLO] = rd_go && (word == W_DLO);
    mon_evt[EV_WR_SIG] = wr_go && (word == W_SIGPRO);
    mon_evt[EV_WR_XD]  = wr_go && (word == W_RSPEXT);
    mon_evt[EV_RD_RSP] = rd_go && (word == W_RSPEXT);
    mon_evt[EV_RD_PRO] = rd_go && (word == W_SIGPRO);
  end

  cfgslv_locmon u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (mon_evt),
    .en       (ctrl_q[MON_N-1:0]),
    .lm_wr    (wr_go && (word == W_LMON)),
    .lm_wdata (bus_wdata),
    .flags    (mon_flags),
    .vector   (mon_vec),
    .irq      (irq_req)
  );

  // read path
  logic [DW-1:0] rd_mux;
  always_comb begin
    case (word)
      W_ID:          rd_mux = ID_WORD;
      W_DEV:         rd_mux = DEV_TYPE;
      W_CSR:         rd_mux = ctrl_q;
      W_SIGPRO:      rd_mux = pro_q;
      W_RSPEXT:      rd_mux = rsp_q;
      W_DHI, W_PDHI: rd_mux = dhi_q;
      W_DLO, W_PDLO: rd_mux = dlo_q;
      W_MODID:       rd_mux = {{(DW-MODID_W-1){1'b0}}, modid_q};
      W_LMON:        rd_mux = {mon_flags, mon_vec};
      W_XDAT:        rd_mux = ext_rdata;
      W_PSIG:        rd_mux = sig_q;
      W_PRSP:        rd_mux = msg_xd_q;
      default:       rd_mux = is_ram(word) ? ram_q[ram_idx(word)] : '0;
    endcase
  end

  logic [DW-1:0] rdata_q;
  logic          ack_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= acc_go | iack_go;
      if (iack_go)    rdata_q <= {{(DW-VEC_W){1'b0}}, mon_vec};
      else if (rd_go) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata   = rdata_q;
  assign bus_ack     = ack_q;
  assign modid_lines = modid_q[MODID_W-1:0];
  assign modid_oe    = modid_q[MODID_W];
  assign ext_addr    = xadr_q;
  assign ext_wdata   = xwd_q;
  assign ext_wr_stb  = xstb_q;

  AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_seen && hit) |-> (bus_addr >= BASE && bus_addr <= BLK_LAST)) else $error("decode"); // R1
  AST_NO_ACK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_seen && !hit && !bus_iack) |=> !bus_ack) else $error("stray ack"); // R1
  AST_ACK_AFTER_DS: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_seen && (hit || bus_iack)) |=> bus_ack) else $error("ack missing"); // R2
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack) else $error("ack too long"); // R2
  AST_IACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    iack_go |=> (bus_rdata[DW-1:VEC_W] == '0)) else $error("iack data"); // R10
  AST_EXT_STB_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_stb |-> bus_ack) else $error("ext strobe"); // R12
endmodule

// File: tb/sim_cfgslv_top.sv
`timescale 1ns/1ps
module sim_cfgslv_top;
  localparam logic [15:0] BASE = 16'hC000 + 16'd0 * 16'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_ds = 1'b0, bus_wr = 1'b0, bus_iack = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0, ext_rdata = 16'hBEEF;
  wire  [15:0] bus_rdata;
  wire         bus_ack, irq_req, modid_oe, ext_wr_stb;
  wire  [12:0] modid_lines;
  wire  [15:0] ext_addr, ext_wdata;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] last_rd;
  logic last_ack, last_irq, last_stb;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfgslv_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_ds(bus_ds), .bus_wr(bus_wr), .bus_iack(bus_iack),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .irq_req(irq_req), .modid_lines(modid_lines), .modid_oe(modid_oe),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_wr_stb(ext_wr_stb), .ext_rdata(ext_rdata)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // strobe at a falling edge, sample at the next one, release
  task automatic cycle(input logic wr, input logic iack, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_iack = iack; bus_wdata = d; bus_ds = 1'b1;
    @(negedge clk);
    last_rd = bus_rdata; last_ack = bus_ack; last_irq = irq_req; last_stb = ext_wr_stb;
    bus_ds = 1'b0; bus_wr = 1'b0; bus_iack = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr16(input logic [15:0] off, input logic [15:0] d);
    cycle(1'b1, 1'b0, BASE + off, d);
  endtask

  task automatic rd16(input logic [15:0] off);
    cycle(1'b0, 1'b0, BASE + off, 16'h0);
  endtask

  task automatic t_reset;
    chk("R2", "ack after reset", {15'b0, bus_ack}, 16'h0);
    chk("R9", "irq after reset", {15'b0, irq_req}, 16'h0);
    chk("R7", "modid oe after reset", {15'b0, modid_oe}, 16'h0);
    chk("R12", "ext_addr after reset", ext_addr, 16'h0);
    chk("R2", "rdata after reset", bus_rdata, 16'h0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    bus_addr = BASE; bus_wr = 1'b0; bus_ds = 1'b1;
    #1 chk("R2", "ack before edge", {15'b0, bus_ack}, 16'h0);
    @(negedge clk);
    chk("R2", "ack one cycle later", {15'b0, bus_ack}, 16'h1);
    chk("R2", "data with ack", bus_rdata, 16'h3A7C);
    @(negedge clk);
    chk("R2", "ack drops with strobe held", {15'b0, bus_ack}, 16'h0);
    bus_ds = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_decode;
    rd16(16'h003E);
    chk("R1", "ack at last word", {15'b0, last_ack}, 16'h1);
    cycle(1'b0, 1'b0, BASE + 16'h0040, 16'h0);
    chk("R1", "no ack above window", {15'b0, last_ack}, 16'h0);
    cycle(1'b1, 1'b0, BASE - 16'h0002, 16'h1111);
    chk("R1", "no ack below window", {15'b0, last_ack}, 16'h0);
    rd16(16'h0003);
    chk("R1", "odd byte reads device type", last_rd, 16'h5E10);
  endtask

  task automatic t_ident;
    wr16(16'h0000, 16'hFFFF);
    wr16(16'h0002, 16'h0000);
    rd16(16'h0000); chk("R3", "id word", last_rd, 16'h3A7C);
    rd16(16'h0002); chk("R3", "device type", last_rd, 16'h5E10);
  endtask

  task automatic t_ram;
    for (int i = 0; i < 8; i++) wr16(16'h0010 + 16'(2*i), 16'hA500 + 16'(i));
    for (int i = 0; i < 4; i++) wr16(16'h0028 + 16'(2*i), 16'h5A00 + 16'(i * 17));
    for (int i = 0; i < 8; i++) begin
      rd16(16'h0010 + 16'(2*i)); chk("R4", "low ram word", last_rd, 16'hA500 + 16'(i));
    end
    for (int i = 0; i < 4; i++) begin
      rd16(16'h0028 + 16'(2*i)); chk("R4", "high ram word", last_rd, 16'h5A00 + 16'(i * 17));
    end
  endtask

  task automatic t_msg;
    wr16(16'h0008, 16'hA1A1);
    wr16(16'h0038, 16'hB2B2);
    rd16(16'h0038); chk("R5", "processor sees signal", last_rd, 16'hA1A1);
    rd16(16'h0008); chk("R5", "bus sees protocol", last_rd, 16'hB2B2);
    wr16(16'h000A, 16'hC3C3);
    wr16(16'h003A, 16'hD4D4);
    rd16(16'h003A); chk("R5", "processor sees ext data", last_rd, 16'hC3C3);
    rd16(16'h000A); chk("R5", "bus sees response", last_rd, 16'hD4D4);
  endtask

  task automatic t_data;
    wr16(16'h000C, 16'h1234);
    rd16(16'h003C); chk("R6", "data high shared", last_rd, 16'h1234);
    wr16(16'h003E, 16'h5678);
    rd16(16'h000E); chk("R6", "data low shared", last_rd, 16'h5678);
  endtask

  task automatic t_modid;
    wr16(16'h0020, 16'hFFFF);
    chk("R7", "lines all set", {3'b0, modid_lines}, 16'h1FFF);
    chk("R7", "oe set", {15'b0, modid_oe}, 16'h1);
    rd16(16'h0020); chk("R7", "readback", last_rd, 16'h3FFF);
    wr16(16'h0020, 16'h0ABC);
    chk("R7", "lines pattern", {3'b0, modid_lines}, 16'h0ABC);
    chk("R7", "oe clear", {15'b0, modid_oe}, 16'h0);
  endtask

  task automatic t_monitor;
    wr16(16'h0004, 16'h0005);
    rd16(16'h0004); chk("R8", "control readback", last_rd, 16'h0005);
    wr16(16'h000C, 16'h1111);
    chk("R8", "irq on enabled write", {15'b0, last_irq}, 16'h1);
    rd16(16'h0022); chk("R8", "flag 0 set", last_rd, 16'h0100);
    wr16(16'h000E, 16'h2222);
    rd16(16'h0022); chk("R8", "disabled event ignored", last_rd, 16'h0100);
    wr16(16'h0022, 16'h015A);
    chk("R9", "irq drops on clear", {15'b0, last_irq}, 16'h0);
    rd16(16'h0022); chk("R9", "flag cleared, vector loaded", last_rd, 16'h005A);
    rd16(16'h000C);
    chk("R8", "read data high", last_rd, 16'h1111);
    chk("R8", "irq on enabled read", {15'b0, last_irq}, 16'h1);
    rd16(16'h0022); chk("R8", "flag 2 set", last_rd, 16'h045A);
    cycle(1'b0, 1'b1, 16'h1234, 16'h0);
    chk("R10", "iack ack", {15'b0, last_ack}, 16'h1);
    chk("R10", "iack vector", last_rd, 16'h005A);
    wr16(16'h0022, 16'h045A);
    chk("R9", "irq drops", {15'b0, last_irq}, 16'h0);
    rd16(16'h003C);
    chk("R8", "processor read no irq", {15'b0, last_irq}, 16'h0);
    rd16(16'h0022); chk("R8", "no flag from processor side", last_rd, 16'h005A);
  endtask

  task automatic t_unused;
    wr16(16'h0006, 16'hFFFF);
    rd16(16'h0006); chk("R11", "offset 06 reads zero", last_rd, 16'h0);
    wr16(16'h0030, 16'hFFFF);
    rd16(16'h0030); chk("R11", "offset 30 reads zero", last_rd, 16'h0);
    rd16(16'h0010); chk("R11", "ram untouched", last_rd, 16'hA500);
  endtask

  task automatic t_ext;
    wr16(16'h0024, 16'h1357);
    chk("R12", "ext_addr", ext_addr, 16'h1357);
    rd16(16'h0024); chk("R11", "ext address reads zero", last_rd, 16'h0);
    wr16(16'h0026, 16'h7777);
    chk("R12", "ext write strobe", {15'b0, last_stb}, 16'h1);
    chk("R12", "ext_wdata", ext_wdata, 16'h7777);
    chk("R12", "strobe is one cycle", {15'b0, ext_wr_stb}, 16'h0);
    rd16(16'h0026); chk("R12", "ext read data", last_rd, 16'hBEEF);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_timing;
    t_decode;
    t_ident;
    t_ram;
    t_msg;
    t_data;
    t_modid;
    t_monitor;
    t_unused;
    t_ext;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule